// File: doc/BRIEF.md
# Power Mode and Slow-Clock Controller

This block keeps track of the power state of a small processor subsystem and turns one master clock into clock-enable pulses for the CPU and for the peripheral domain. It leaves reset in the full-speed state. Software sets a slow-clock enable and a two-bit divide ratio through a control register write port. Once the slow enable is in force, CPU and peripherals share one reduced enable rate.

Two instruction strobes ask for the low-power states. The wait strobe stops the CPU while the peripherals keep running. The halt strobe stops more or less of the device, depending on a flag that says whether the oscillator stays alive. Wake-up comes from interrupt inputs or from reset. A three-bit code reports the present state. The enables are meant to drive clock-gating cells that sit outside this block.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode is RUN (code 0). In RUN, `cpu_ce` and `per_ce` are high on every cycle.
- R2: A control write with `ctl_slow`=1 and ratio k selects a period of 2^(k+1) cycles: 00 gives /2, 01 gives /4, 10 gives /8 and 11 gives /16. The mode is then SLOW (code 1), and `cpu_ce` and `per_ce` pulse together. Writing `ctl_slow`=0 returns the block to RUN.
- R3: In SLOW mode each enable pulse is one cycle wide, and consecutive pulses are exactly one period apart.
- R4: A control write takes effect only at the end of the period that is running when it is written. The pulse that follows the write keeps the old spacing, and the pulses after it use the new spacing.
- R5: `wait_req` in RUN enters WAIT (code 2) at the next clock edge. In WAIT, `cpu_ce` stays low and `per_ce` keeps its rate.
- R6: `wait_req` in SLOW enters SLOW WAIT (code 3). In this state `cpu_ce` stays low and `per_ce` keeps the divided rate.
- R7: `halt_req` with `osc_keep`=1 enters ACTIVE HALT (code 4). In this state `cpu_ce` and `per_ce` stay low, and `wkt_ce` pulses at the current period. When `halt_req` and `wait_req` arrive together, the halt request wins.
- R8: `halt_req` with `osc_keep`=0 enters HALT (code 5), and all three enables stay low.
- R9: `irq_any` or `irq_ext` in WAIT, SLOW WAIT or ACTIVE HALT returns the block to RUN or SLOW, whichever the slow setting selects.
- R10: Only `irq_ext` or reset ends HALT. `irq_any` alone leaves the block in HALT.
- R11: Wait and halt requests are ignored outside RUN and SLOW. Interrupts are ignored in RUN and SLOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_slow | input | 1 | Slow-clock enable field |
| ctl_ratio | input | RATIO_W | Divide ratio field; k selects /2^(k+1) |
| wait_req | input | 1 | Wait instruction strobe |
| halt_req | input | 1 | Halt instruction strobe |
| osc_keep | input | 1 | Oscillator is kept running during halt |
| irq_any | input | 1 | Any enabled interrupt pending |
| irq_ext | input | 1 | External interrupt pending |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| wkt_ce | output | 1 | Wake-up timer tick enable |
| mode | output | 3 | Current power mode code |

## Verification
The bench sweeps all four divide ratios and measures the gap between successive enable pulses. An off-by-one in the divider, or a mix-up in the ratio decode, shows up as a wrong gap. A write that lands in the middle of a /16 period followed by a switch to /2 separates a deferred update from one that cuts the period short. Every entry path into a low-power state is driven from both RUN and SLOW, including simultaneous wait and halt requests and both values of the oscillator flag. Wake-up is tried with each interrupt input in turn, which shows whether HALT accepts only the external interrupt and whether the block returns to the correct full-speed or slow state.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;

  typedef enum logic [1:0] {
    ST_ACT   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_AHALT = 2'd2,
    ST_HALT  = 2'd3
  } pstate_t;

  localparam logic [2:0] MODE_RUN   = 3'd0;
  localparam logic [2:0] MODE_SLOW  = 3'd1;
  localparam logic [2:0] MODE_WAIT  = 3'd2;
  localparam logic [2:0] MODE_SWAIT = 3'd3;
  localparam logic [2:0] MODE_AHALT = 3'd4;
  localparam logic [2:0] MODE_HALT  = 3'd5;

endpackage

// File: rtl/pwr_clk_div.sv
module pwr_clk_div #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               ctl_wr,
  input  logic               ctl_slow,
  input  logic [RATIO_W-1:0] ctl_ratio,
  output logic               tick,
  output logic               slow_act
);
  // Largest period is 2^(2^RATIO_W); its terminal count needs 2^RATIO_W bits.
  localparam int CNT_W = 1 << RATIO_W;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               pend_slow_q, act_slow_q;
  logic [RATIO_W-1:0] pend_ratio_q, act_ratio_q;
  logic [RATIO_W:0]   shift_amt;
  logic [CNT_W:0]     period;
  logic [CNT_W-1:0]   last_cnt;

  always_comb begin
    shift_amt = {1'b0, act_ratio_q} + (RATIO_W+1)'(1);
    period    = (CNT_W+1)'(1) << shift_amt;
    last_cnt  = act_slow_q ? CNT_W'(period - (CNT_W+1)'(1)) : '0;
    tick      = run && (cnt_q == last_cnt);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Software-visible shadow of the control fields.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_slow_q  <= 1'b0;
      pend_ratio_q <= '0;
    end else if (ctl_wr) begin
      pend_slow_q  <= ctl_slow;
      pend_ratio_q <= ctl_ratio;
    end
  end

  // Active setting changes only on a period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_slow_q  <= 1'b0;
      act_ratio_q <= '0;
    end else if (tick) begin
      act_slow_q  <= ctl_wr ? ctl_slow  : pend_slow_q;
      act_ratio_q <= ctl_wr ? ctl_ratio : pend_ratio_q;
    end
  end

  assign slow_act = act_slow_q;

endmodule

// File: rtl/pwr_clk_fsm.sv
module pwr_clk_fsm
  import pwr_clk_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wait_req,
  input  logic    halt_req,
  input  logic    osc_keep,
  input  logic    irq_any,
  input  logic    irq_ext,
  output pstate_t state
);
  pstate_t state_q, state_d;
  logic    wake;

  always_comb begin
    wake    = irq_any | irq_ext;
    state_d = state_q;
    unique case (state_q)
      ST_ACT: begin
        if (halt_req)      state_d = osc_keep ? ST_AHALT : ST_HALT;
        else if (wait_req) state_d = ST_WAIT;
      end
      ST_WAIT:  if (wake)    state_d = ST_ACT;
      ST_AHALT: if (wake)    state_d = ST_ACT;
      ST_HALT:  if (irq_ext) state_d = ST_ACT;
      default:               state_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACT;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_clk_pkg::*;
#(
  parameter int RATIO_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               ctl_slow,
  input  logic [RATIO_W-1:0] ctl_ratio,
  input  logic               wait_req,
  input  logic               halt_req,
  input  logic               osc_keep,
  input  logic               irq_any,
  input  logic               irq_ext,
  output logic               cpu_ce,
  output logic               per_ce,
  output logic               wkt_ce,
  output logic [2:0]         mode
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  pstate_t                state;
  logic                   tick, slow_act, run;

  // Reset asserts at once and releases after SYNC_STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  pwr_clk_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wait_req (wait_req),
    .halt_req (halt_req),
    .osc_keep (osc_keep),
    .irq_any  (irq_any),
    .irq_ext  (irq_ext),
    .state    (state)
  );

  assign run = (state != ST_HALT);

  pwr_clk_div #(.RATIO_W(RATIO_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .ctl_wr    (ctl_wr),
    .ctl_slow  (ctl_slow),
    .ctl_ratio (ctl_ratio),
    .tick      (tick),
    .slow_act  (slow_act)
  );

  always_comb begin
    cpu_ce = tick && (state == ST_ACT);
    per_ce = tick && (state == ST_ACT || state == ST_WAIT);
    wkt_ce = tick && (state == ST_AHALT);
    unique case (state)
      ST_ACT:   mode = slow_act ? MODE_SLOW  : MODE_RUN;
      ST_WAIT:  mode = slow_act ? MODE_SWAIT : MODE_WAIT;
      ST_AHALT: mode = MODE_AHALT;
      default:  mode = MODE_HALT;
    endcase
  end

endmodule

// File: rtl/pwr_clk_chk.sv
module pwr_clk_chk
  import pwr_clk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wait_req,
  input logic       halt_req,
  input logic       irq_ext,
  input logic       cpu_ce,
  input logic       per_ce,
  input logic       wkt_ce,
  input logic [2:0] mode
);

  a_r1_run_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN) |-> (cpu_ce && per_ce));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ce && mode == MODE_SLOW) |=> (mode != MODE_SLOW || !per_ce));

  a_r5_cpu_off_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WAIT || mode == MODE_SWAIT) |-> !cpu_ce);

  a_r6_slow_to_swait: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLOW && wait_req && !halt_req && !per_ce) |=> (mode == MODE_SWAIT));

  a_r7_ahalt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_AHALT) |-> (!cpu_ce && !per_ce));

  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALT) |-> (!cpu_ce && !per_ce && !wkt_ce));

  a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HALT && !irq_ext) |=> (mode == MODE_HALT));

endmodule

bind pwr_clk_ctrl pwr_clk_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wait_req (wait_req),
  .halt_req (halt_req),
  .irq_ext  (irq_ext),
  .cpu_ce   (cpu_ce),
  .per_ce   (per_ce),
  .wkt_ce   (wkt_ce),
  .mode     (mode)
);

// File: tb/pwr_clk_ctrl_test.sv
module pwr_clk_ctrl_test;
  logic       clk;
  logic       rst_n;
  logic       ctl_wr, ctl_slow;
  logic [1:0] ctl_ratio;
  logic       wait_req, halt_req, osc_keep, irq_any, irq_ext;
  logic       cpu_ce, per_ce, wkt_ce;
  logic [2:0] mode;

  int checks = 0;
  int fails  = 0;

  pwr_clk_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_slow(ctl_slow),
    .ctl_ratio(ctl_ratio), .wait_req(wait_req), .halt_req(halt_req),
    .osc_keep(osc_keep), .irq_any(irq_any), .irq_ext(irq_ext),
    .cpu_ce(cpu_ce), .per_ce(per_ce), .wkt_ce(wkt_ce), .mode(mode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0:       return cpu_ce;
      1:       return per_ce;
      default: return wkt_ce;
    endcase
  endfunction

  // Number of cycles until the selected enable is next seen high.
  task automatic gap(input int sel, output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!pick(sel) && g < 100);
  endtask

  task automatic count(input int sel, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pick(sel)) c++;
    end
  endtask

  task automatic wr_ctl(input logic s, input logic [1:0] r);
    ctl_wr = 1'b1; ctl_slow = s; ctl_ratio = r;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_in(input int which);
    case (which)
      0: wait_req = 1'b1;
      1: halt_req = 1'b1;
      2: irq_any  = 1'b1;
      default: irq_ext = 1'b1;
    endcase
    @(negedge clk);
    wait_req = 1'b0; halt_req = 1'b0; irq_any = 1'b0; irq_ext = 1'b0;
  endtask

  task automatic settle(input int sel);
    int g;
    gap(sel, g);
    gap(sel, g);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int g, c;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_slow = 1'b0; ctl_ratio = 2'd0;
    wait_req = 1'b0; halt_req = 1'b0; osc_keep = 1'b0;
    irq_any = 1'b0; irq_ext = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 cpu_ce", cpu_ce, 1);
    chk("R1 per_ce", per_ce, 1);
    count(0, 10, c);
    chk("R1 cpu rate", c, 10);

    // R2/R3 sweep of all ratios
    for (int k = 0; k < 4; k++) begin
      wr_ctl(1'b1, 2'(k));
      settle(0);
      chk("R2 mode slow", mode, 1);
      chk("R2 per with cpu", per_ce, 1);
      for (int j = 0; j < 3; j++) begin
        gap(0, g);
        chk("R2 period", g, 2 ** (k + 1));
      end
      @(negedge clk);
      chk("R3 pulse width", cpu_ce, 0);
      gap(1, g);
      chk("R3 per period", g, 2 ** (k + 1) - 1);
    end

    // R4 deferred ratio change: now at /16, at a pulse
    @(negedge clk);
    wr_ctl(1'b1, 2'd0);
    gap(0, g);
    chk("R4 old period kept", g + 2, 16);
    gap(0, g);
    chk("R4 new period", g, 2);

    // slow off returns to RUN
    wr_ctl(1'b0, 2'd0);
    settle(0);
    chk("R2 back to run", mode, 0);

    // R6 wait from SLOW /4
    wr_ctl(1'b1, 2'd1);
    settle(0);
    @(negedge clk);
    pulse_in(0);
    chk("R6 mode swait", mode, 3);
    count(0, 20, c);
    chk("R6 cpu stopped", c, 0);
    gap(1, g);
    gap(1, g);
    chk("R6 per rate", g, 4);
    pulse_in(0);
    pulse_in(1);
    chk("R11 req ignored in swait", mode, 3);
    pulse_in(2);
    chk("R9 wake to slow", mode, 1);

    // R5 wait from RUN
    wr_ctl(1'b0, 2'd0);
    settle(0);
    pulse_in(0);
    chk("R5 mode wait", mode, 2);
    count(1, 12, c);
    chk("R5 per full rate", c, 12);
    count(0, 12, c);
    chk("R5 cpu stopped", c, 0);
    pulse_in(3);
    chk("R9 ext wake to run", mode, 0);

    // R7 active halt at /8, halt beats wait
    wr_ctl(1'b1, 2'd2);
    settle(0);
    osc_keep = 1'b1;
    wait_req = 1'b1;
    pulse_in(1);
    chk("R7 mode ahalt", mode, 4);
    count(2, 32, c);
    chk("R7 wkt ticks", c, 4);
    count(1, 16, c);
    chk("R7 per stopped", c, 0);
    pulse_in(2);
    chk("R9 ahalt wake", mode, 1);

    // R8/R10 full halt
    wr_ctl(1'b0, 2'd0);
    settle(0);
    osc_keep = 1'b0;
    pulse_in(1);
    chk("R8 mode halt", mode, 5);
    count(0, 10, c); chk("R8 cpu off", c, 0);
    count(1, 10, c); chk("R8 per off", c, 0);
    count(2, 10, c); chk("R8 wkt off", c, 0);
    pulse_in(2);
    chk("R10 irq_any ignored", mode, 5);
    pulse_in(0);
    chk("R11 wait ignored in halt", mode, 5);
    pulse_in(3);
    chk("R10 ext wake", mode, 0);
    pulse_in(2);
    chk("R11 irq ignored in run", mode, 0);

    // R10 reset ends HALT
    pulse_in(1);
    chk("R8 halt again", mode, 5);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 reset wake", mode, 0);
    chk("R1 cpu after reset", cpu_ce, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule